// File: doc/BRIEF.md
# Optical-drive READ CD command decoder

This block sits behind the packet-command path of an optical-drive storage target. Issuing a packet command arms it. Two bits of the feature register are captured at that moment. One requests overlapped operation, which is refused. The other selects a DMA data phase rather than PIO.

The twelve command bytes then arrive one per valid strobe. The decoder picks out the starting block address, the sector count and the transfer-request byte as they pass. Once the twelfth byte arrives, it applies a fixed chain of checks against the medium-present flag and the media size. It then emits a single-cycle result with one of four codes:
- completion with no data,
- an error with a sense key and additional sense code,
- a read request carrying block, count, sector size and DMA flag,
- an abort.

A small tail stage follows a DMA read. When the data mover reports that the DMA phase has ended, the tail raises an interrupt pulse and updates the low bits of the interrupt-reason field.

Top module: `cd_read_decoder`

## Requirements
- R1: If `feature_i[1]` is high while `cmd_issue_i` is high, the cycle after issue carries a result with code 3 (abort), and any bytes sent before the next issue produce no result.
- R2: The result pulse `res_valid_o` is high for exactly the one cycle after the clock edge that accepts the twelfth byte of an armed packet. Bytes strobed while no packet is armed are ignored.
- R3: On a read result, `lba_o` is packet bytes 2..5 (byte 2 most significant) and `count_o` is bytes 6..8 (byte 6 most significant).
- R4: With `medium_present_i` low at the twelfth byte, the result is code 1 (error) with sense key 0x2 and ASC 0x3A, whatever the other fields hold.
- R5: With a medium present and a count of zero, the result is code 0 (ok), before any range or transfer-request check.
- R6: The range check fails when (lba+count)*4, compared in 512-byte units, is greater than `media_size_i`. The result is then code 1 with sense key 0x5 and ASC 0x21. Equality passes.
- R7: Byte 9 AND 0xF8 selects the action. 0x00 gives code 0. 0x10 gives code 2 (read) with `sec_size_o` = 2048. 0xF8 gives code 2 with `sec_size_o` = 2352.
- R8: Any other masked value of byte 9 gives code 1 with sense key 0x5 and ASC 0x24.
- R9: `dma_o` on a read result equals `feature_i[0]` sampled at issue.
- R10: After a read result with `dma_o` = 1, the first `dma_done_i` raises `irq_o` for one cycle and sets `int_reason_o` to 3'b011 (bit0 command/data, bit1 to-host). A `dma_done_i` with no DMA read pending is ignored.
- R11: After reset, `res_valid_o` and `irq_o` are low and `int_reason_o` is 3'b000.
- R12: Every `cmd_issue_i` sets `int_reason_o` to 3'b001 and restarts byte collection, which discards any partial packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_issue_i | input | 1 | Packet command issued (one cycle) |
| feature_i | input | 2 | Feature bits at issue: [1] overlap request, [0] DMA select |
| byte_valid_i | input | 1 | Packet byte strobe |
| byte_i | input | 8 | Packet byte |
| medium_present_i | input | 1 | Medium loaded |
| media_size_i | input | SIZE_W | Media size in 512-byte units |
| dma_done_i | input | 1 | DMA data phase finished (one cycle) |
| res_valid_o | output | 1 | Result pulse |
| res_code_o | output | 2 | 0 ok, 1 error, 2 read, 3 abort |
| sense_key_o | output | 4 | Sense key on error |
| asc_o | output | 8 | Additional sense code on error |
| lba_o | output | 32 | Starting block of read |
| count_o | output | 24 | Sector count of read |
| sec_size_o | output | 12 | Sector size of read in bytes |
| dma_o | output | 1 | Read uses DMA |
| irq_o | output | 1 | Interrupt pulse at DMA end |
| int_reason_o | output | 3 | Interrupt-reason low bits |

## Verification
The assertions assume the following about the inputs:
- `cmd_issue_i` and `dma_done_i` are single-cycle pulses.
- `medium_present_i` and `media_size_i` are settled at the edge that takes the twelfth byte, because the no-medium check compares the result with the flag as it was at that edge.

The bench drives every input on the falling clock edge. It never raises an issue and a byte strobe together, pulses issue and DMA-done for one cycle only, and holds the medium flag and media size constant across each whole packet.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  localparam int PKT_BYTES = 12;
  localparam int IDX_W     = 4;
  localparam int LBA_W     = 32;
  localparam int CNT_W     = 24;
  localparam int SZ_W      = 12;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_ERR   = 2'd1,
    RES_READ  = 2'd2,
    RES_ABORT = 2'd3
  } res_e;

  localparam logic [3:0]  SK_NOT_READY = 4'h2;
  localparam logic [3:0]  SK_ILLEGAL   = 4'h5;
  localparam logic [7:0]  ASC_NO_MEDIA = 8'h3A;
  localparam logic [7:0]  ASC_RANGE    = 8'h21;
  localparam logic [7:0]  ASC_BAD_FLD  = 8'h24;

  localparam logic [7:0]  XFER_MASK = 8'hF8;
  localparam logic [7:0]  XFER_NONE = 8'h00;
  localparam logic [7:0]  XFER_USER = 8'h10;
  localparam logic [7:0]  XFER_RAW  = 8'hF8;

  localparam logic [SZ_W-1:0] SZ_USER = 12'd2048;
  localparam logic [SZ_W-1:0] SZ_RAW  = 12'd2352;
endpackage

// File: rtl/rcd_collect.sv
module rcd_collect
  import rcd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [1:0]       feat_i,
  input  logic             bvalid_i,
  input  logic [7:0]       byte_i,
  output logic             abort_o,
  output logic             last_o,
  output logic [LBA_W-1:0] lba_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [7:0]       xfer_o,
  output logic             dma_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_BYTES - 1);

  logic             armed_q;
  logic [IDX_W-1:0] idx_q;
  logic [LBA_W-1:0] lba_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       xfer_q;
  logic             dma_q;
  logic             take;

  assign take    = bvalid_i && armed_q && !issue_i;
  assign abort_o = issue_i && feat_i[1];
  assign last_o  = take && (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      idx_q   <= '0;
      lba_q   <= '0;
      cnt_q   <= '0;
      xfer_q  <= '0;
      dma_q   <= 1'b0;
    end else if (issue_i) begin
      armed_q <= !feat_i[1];
      idx_q   <= '0;
      dma_q   <= feat_i[0];
    end else if (take) begin
      // fields shift in big-endian as they pass
      if (idx_q >= 4'd2 && idx_q <= 4'd5) lba_q <= {lba_q[LBA_W-9:0], byte_i};
      if (idx_q >= 4'd6 && idx_q <= 4'd8) cnt_q <= {cnt_q[CNT_W-9:0], byte_i};
      if (idx_q == 4'd9) xfer_q <= byte_i;
      if (idx_q == LAST_IDX) begin
        armed_q <= 1'b0;
        idx_q   <= '0;
      end else begin
        idx_q   <= idx_q + 1'b1;
      end
    end
  end

  assign lba_o  = lba_q;
  assign cnt_o  = cnt_q;
  assign xfer_o = xfer_q;
  assign dma_o  = dma_q;

  // R2
  idx_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX);
  // R2
  idle_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> idx_q == '0);
endmodule

// File: rtl/rcd_eval.sv
module rcd_eval
  import rcd_pkg::*;
#(
  parameter int SIZE_W = 40
) (
  input  logic [LBA_W-1:0]  lba_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [7:0]        xfer_i,
  input  logic              medium_i,
  input  logic [SIZE_W-1:0] media_size_i,
  output res_e              code_o,
  output logic [3:0]        sk_o,
  output logic [7:0]        asc_o,
  output logic [SZ_W-1:0]   size_o
);
  localparam int SUM_W = LBA_W + 3;
  localparam int CMP_W = (SUM_W > SIZE_W) ? SUM_W : SIZE_W;

  logic [LBA_W:0]   end_blk;
  logic [CMP_W-1:0] end_units;
  logic [CMP_W-1:0] limit;

  assign end_blk   = {1'b0, lba_i} + (LBA_W + 1)'(cnt_i);
  assign end_units = CMP_W'({end_blk, 2'b00});
  assign limit     = CMP_W'(media_size_i);

  always_comb begin
    code_o = RES_OK;
    sk_o   = '0;
    asc_o  = '0;
    size_o = '0;
    if (!medium_i) begin
      code_o = RES_ERR;
      sk_o   = SK_NOT_READY;
      asc_o  = ASC_NO_MEDIA;
    end else if (cnt_i == '0) begin
      code_o = RES_OK;
    end else if (end_units > limit) begin
      code_o = RES_ERR;
      sk_o   = SK_ILLEGAL;
      asc_o  = ASC_RANGE;
    end else begin
      case (xfer_i & XFER_MASK)
        XFER_NONE: code_o = RES_OK;
        XFER_USER: begin
          code_o = RES_READ;
          size_o = SZ_USER;
        end
        XFER_RAW: begin
          code_o = RES_READ;
          size_o = SZ_RAW;
        end
        default: begin
          code_o = RES_ERR;
          sk_o   = SK_ILLEGAL;
          asc_o  = ASC_BAD_FLD;
        end
      endcase
    end
  end
endmodule

// File: rtl/rcd_dma_tail.sv
module rcd_dma_tail (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       arm_i,
  input  logic       done_i,
  output logic       irq_o,
  output logic [2:0] reason_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      irq_o    <= 1'b0;
      reason_o <= 3'b000;
    end else begin
      irq_o <= 1'b0;
      if (clear_i) begin
        pend_q   <= 1'b0;
        reason_o <= 3'b001;
      end else if (arm_i) begin
        pend_q   <= 1'b1;
      end else if (done_i && pend_q) begin
        pend_q   <= 1'b0;
        irq_o    <= 1'b1;
        reason_o <= 3'b011;
      end
    end
  end

  // R10
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(done_i));
  // R10
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: rtl/cd_read_decoder.sv
module cd_read_decoder
  import rcd_pkg::*;
#(
  parameter int SIZE_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_issue_i,
  input  logic [1:0]        feature_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              medium_present_i,
  input  logic [SIZE_W-1:0] media_size_i,
  input  logic              dma_done_i,
  output logic              res_valid_o,
  output logic [1:0]        res_code_o,
  output logic [3:0]        sense_key_o,
  output logic [7:0]        asc_o,
  output logic [31:0]       lba_o,
  output logic [23:0]       count_o,
  output logic [11:0]       sec_size_o,
  output logic              dma_o,
  output logic              irq_o,
  output logic [2:0]        int_reason_o
);
  logic             abort, last, pkt_dma;
  logic [LBA_W-1:0] pkt_lba;
  logic [CNT_W-1:0] pkt_cnt;
  logic [7:0]       pkt_xfer;
  res_e             ev_code;
  logic [3:0]       ev_sk;
  logic [7:0]       ev_asc;
  logic [SZ_W-1:0]  ev_size;
  res_e             code_q;

  rcd_collect u_collect (
    .clk_i, .rst_ni,
    .issue_i  (cmd_issue_i),
    .feat_i   (feature_i),
    .bvalid_i (byte_valid_i),
    .byte_i,
    .abort_o  (abort),
    .last_o   (last),
    .lba_o    (pkt_lba),
    .cnt_o    (pkt_cnt),
    .xfer_o   (pkt_xfer),
    .dma_o    (pkt_dma)
  );

  rcd_eval #(.SIZE_W(SIZE_W)) u_eval (
    .lba_i        (pkt_lba),
    .cnt_i        (pkt_cnt),
    .xfer_i       (pkt_xfer),
    .medium_i     (medium_present_i),
    .media_size_i,
    .code_o       (ev_code),
    .sk_o         (ev_sk),
    .asc_o        (ev_asc),
    .size_o       (ev_size)
  );

  rcd_dma_tail u_tail (
    .clk_i, .rst_ni,
    .clear_i  (cmd_issue_i),
    .arm_i    (last && ev_code == RES_READ && pkt_dma),
    .done_i   (dma_done_i),
    .irq_o,
    .reason_o (int_reason_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      code_q      <= RES_OK;
      sense_key_o <= '0;
      asc_o       <= '0;
      lba_o       <= '0;
      count_o     <= '0;
      sec_size_o  <= '0;
      dma_o       <= 1'b0;
    end else begin
      res_valid_o <= abort || last;
      if (abort) begin
        code_q      <= RES_ABORT;
        sense_key_o <= '0;
        asc_o       <= '0;
        sec_size_o  <= '0;
        dma_o       <= 1'b0;
      end else if (last) begin
        code_q      <= ev_code;
        sense_key_o <= ev_sk;
        asc_o       <= ev_asc;
        lba_o       <= pkt_lba;
        count_o     <= pkt_cnt;
        sec_size_o  <= ev_size;
        dma_o       <= pkt_dma;
      end
    end
  end

  assign res_code_o = code_q;

  // R1
  abort_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_issue_i && feature_i[1]) |=> res_valid_o && res_code_o == RES_ABORT);
  // R4
  no_medium_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_code_o != RES_ABORT && !$past(medium_present_i))
      |-> res_code_o == RES_ERR && sense_key_o == SK_NOT_READY);
  // R5
  read_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_code_o == RES_READ) |-> count_o != '0);
  // R7
  read_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_code_o == RES_READ) |-> (sec_size_o == SZ_USER || sec_size_o == SZ_RAW));
endmodule

// File: tb/cd_read_decoder_tb.sv
module cd_read_decoder_tb;
  import rcd_pkg::*;

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] lba;
    logic [23:0] cnt;
    logic [7:0]  xfer;
    logic        med;
    logic [39:0] msize;
    logic [1:0]  feat;
    logic [1:0]  code;
    logic [3:0]  sk;
    logic [7:0]  asc;
    logic [11:0] size;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'd4,  32'd5,          24'd3,       8'h10, 1'b0, 40'd1000,           2'b00, 2'd1, 4'h2, 8'h3A, 12'd0},    // R4
    '{4'd5,  32'hFFFFFF00,   24'd0,       8'h20, 1'b1, 40'd16,             2'b00, 2'd0, 4'h0, 8'h00, 12'd0},    // R5
    '{4'd6,  32'd100,        24'd1,       8'h10, 1'b1, 40'd400,            2'b00, 2'd1, 4'h5, 8'h21, 12'd0},    // R6
    '{4'd6,  32'd99,         24'd1,       8'h10, 1'b1, 40'd400,            2'b00, 2'd2, 4'h0, 8'h00, 12'd2048}, // R6 equality
    '{4'd7,  32'd7,          24'd2,       8'hF8, 1'b1, 40'd400,            2'b00, 2'd2, 4'h0, 8'h00, 12'd2352}, // R7
    '{4'd7,  32'd7,          24'd2,       8'hFF, 1'b1, 40'd400,            2'b00, 2'd2, 4'h0, 8'h00, 12'd2352}, // R7
    '{4'd3,  32'h01020304,   24'h050607,  8'h17, 1'b1, 40'h40_0000_0000,   2'b00, 2'd2, 4'h0, 8'h00, 12'd2048}, // R3
    '{4'd7,  32'd7,          24'd2,       8'h07, 1'b1, 40'd400,            2'b00, 2'd0, 4'h0, 8'h00, 12'd0},    // R7
    '{4'd8,  32'd7,          24'd2,       8'h20, 1'b1, 40'd400,            2'b00, 2'd1, 4'h5, 8'h24, 12'd0},    // R8
    '{4'd8,  32'd7,          24'd2,       8'h08, 1'b1, 40'd400,            2'b00, 2'd1, 4'h5, 8'h24, 12'd0},    // R8
    '{4'd9,  32'hFFFFFFFF,   24'd1,       8'h10, 1'b1, 40'hFF_FFFF_FFFF,   2'b01, 2'd2, 4'h0, 8'h00, 12'd2048}, // R9
    '{4'd4,  32'd3,          24'd2,       8'h30, 1'b0, 40'd4,              2'b00, 2'd1, 4'h2, 8'h3A, 12'd0}     // R4 precedence
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_issue_i = 1'b0;
  logic [1:0]  feature_i = '0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        medium_present_i = 1'b1;
  logic [39:0] media_size_i = '0;
  logic        dma_done_i = 1'b0;
  logic        res_valid_o;
  logic [1:0]  res_code_o;
  logic [3:0]  sense_key_o;
  logic [7:0]  asc_o;
  logic [31:0] lba_o;
  logic [23:0] count_o;
  logic [11:0] sec_size_o;
  logic        dma_o;
  logic        irq_o;
  logic [2:0]  int_reason_o;

  int tests = 0;
  int fails = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  cd_read_decoder u_dut (.*);

  always @(negedge clk_i) if (res_valid_o) pulses++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] f);
    feature_i = f;
    cmd_issue_i = 1'b1;
    @(negedge clk_i);
    cmd_issue_i = 1'b0;
  endtask

  function automatic logic [7:0] pbyte(input int i, input logic [31:0] l,
                                       input logic [23:0] c, input logic [7:0] x);
    case (i)
      0: pbyte = 8'hBE;
      2: pbyte = l[31:24];
      3: pbyte = l[23:16];
      4: pbyte = l[15:8];
      5: pbyte = l[7:0];
      6: pbyte = c[23:16];
      7: pbyte = c[15:8];
      8: pbyte = c[7:0];
      9: pbyte = x;
      default: pbyte = 8'h00;
    endcase
  endfunction

  task automatic send(input int n, input logic [31:0] l, input logic [23:0] c, input logic [7:0] x);
    for (int i = 0; i < n; i++) begin
      byte_valid_i = 1'b1;
      byte_i = pbyte(i, l, c, x);
      @(negedge clk_i);
    end
    byte_valid_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(res_valid_o == 1'b0, "R11 valid", res_valid_o, 0);
    chk(irq_o == 1'b0, "R11 irq", irq_o, 0);
    chk(int_reason_o == 3'b000, "R11 reason", int_reason_o, 0);

    // R2: stray bytes without an armed packet
    media_size_i = 40'd400;
    p0 = pulses;
    send(12, 32'd1, 24'd1, 8'h10);
    @(negedge clk_i);
    chk(pulses == p0, "R2 stray bytes", pulses - p0, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      string rq;
      rq = $sformatf("R%0d vec%0d", VECS[v].req, v);
      medium_present_i = VECS[v].med;
      media_size_i = VECS[v].msize;
      issue(VECS[v].feat);
      send(12, VECS[v].lba, VECS[v].cnt, VECS[v].xfer);
      chk(res_valid_o == 1'b1, {rq, " valid"}, res_valid_o, 1);
      chk(res_code_o == VECS[v].code, {rq, " code"}, res_code_o, VECS[v].code);
      if (VECS[v].code == 2'd2) begin
        chk(lba_o == VECS[v].lba, {rq, " lba"}, lba_o, VECS[v].lba);
        chk(count_o == VECS[v].cnt, {rq, " count"}, count_o, VECS[v].cnt);
        chk(sec_size_o == VECS[v].size, {rq, " size"}, sec_size_o, VECS[v].size);
        chk(dma_o == VECS[v].feat[0], {rq, " dma"}, dma_o, VECS[v].feat[0]);
      end else if (VECS[v].code == 2'd1) begin
        chk(sense_key_o == VECS[v].sk, {rq, " sense"}, sense_key_o, VECS[v].sk);
        chk(asc_o == VECS[v].asc, {rq, " asc"}, asc_o, VECS[v].asc);
      end
      @(negedge clk_i);
      chk(res_valid_o == 1'b0, "R2 single pulse", res_valid_o, 0);
    end

    // R1: overlap request aborts, following bytes ignored
    medium_present_i = 1'b1;
    media_size_i = 40'd400;
    issue(2'b10);
    chk(res_valid_o && res_code_o == 2'd3, "R1 abort", res_code_o, 3);
    @(negedge clk_i);
    p0 = pulses;
    send(12, 32'd1, 24'd1, 8'h10);
    @(negedge clk_i);
    chk(pulses == p0, "R1 bytes after abort", pulses - p0, 0);

    // R12: restart discards partial packet
    issue(2'b00);
    send(5, 32'hAAAAAAAA, 24'd9, 8'hF8);
    issue(2'b00);
    chk(int_reason_o == 3'b001, "R12 reason on issue", int_reason_o, 1);
    send(12, 32'd20, 24'd4, 8'h10);
    chk(res_valid_o && lba_o == 32'd20, "R12 restart lba", lba_o, 20);
    chk(count_o == 24'd4 && sec_size_o == 12'd2048, "R12 restart count", count_o, 4);

    // R10: DMA tail
    issue(2'b01);
    send(12, 32'd10, 24'd2, 8'h10);
    chk(res_code_o == 2'd2 && dma_o, "R9 dma read", dma_o, 1);
    @(negedge clk_i);
    dma_done_i = 1'b1;
    @(negedge clk_i);
    dma_done_i = 1'b0;
    chk(irq_o == 1'b1, "R10 irq", irq_o, 1);
    chk(int_reason_o == 3'b011, "R10 reason", int_reason_o, 3);
    @(negedge clk_i);
    chk(irq_o == 1'b0, "R10 irq pulse", irq_o, 0);
    dma_done_i = 1'b1;
    @(negedge clk_i);
    dma_done_i = 1'b0;
    chk(irq_o == 1'b0, "R10 second done ignored", irq_o, 0);

    // R10: PIO read never pends
    issue(2'b00);
    send(12, 32'd10, 24'd2, 8'h10);
    chk(res_code_o == 2'd2 && !dma_o, "R9 pio read", dma_o, 0);
    dma_done_i = 1'b1;
    @(negedge clk_i);
    dma_done_i = 1'b0;
    chk(irq_o == 1'b0, "R10 pio done ignored", irq_o, 0);
    chk(int_reason_o == 3'b001, "R10 pio reason", int_reason_o, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule